// File: doc/BRIEF.md
# GPIO Bank Register Controller

This block is the per-bank state holder for up to 32 general-purpose pins. Software reaches it over a simple 32-bit register bus (address, write strobe, write data, combinational read data). Seven per-pin state registers (output data, interrupt mask, pull, function, select, direction and trigger) each appear at a readable base offset. Each also has two write-only aliases: one that sets the bits written as one, and one that clears them. Several agents can therefore change single pins without a read-modify-write sequence.

From the stored state the block drives the pad controls: output enable, output value, pull-up enable, and a two-bit role code per pin that picks plain GPIO or one of three alternate functions. Pad levels pass through a two-stage synchronizer and can be read at offset 0x00. A bank may be built with fewer than 32 pins. The missing pins then have no storage and read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A write to a group's set alias (base + 0x4) sets every state bit written as one and leaves bits written as zero unchanged, visible on the next cycle.
- R2: A write to a group's clear alias (base + 0x8) clears every state bit written as one and leaves bits written as zero unchanged.
- R3: Reading a group's base offset returns its state register. The base offsets are output data 0x10, interrupt mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60 and trigger 0x70. Address bits [7:4] select the group and bits [3:0] select base (0x0), set (0x4) or clear (0x8).
- R4: Offset 0x00 returns the pad input levels delayed by two clock edges, not the output data register. It is read-only.
- R5: After reset every state register is zero. Every implemented pin is then a GPIO input (pad_oe 0, role 0) with its pull-up enabled.
- R6: pad_role[2i+1:2i] for pin i is 0 (GPIO) when the function bit is 0. When the function bit is 1 it is 1 if select=0, 2 if select=1 and trigger=0, and 3 if select=1 and trigger=1.
- R7: pad_oe[i] equals the direction bit when pin i is in the GPIO role, and is 0 when the pin is in an alternate role.
- R8: pad_out[i] equals the output data bit of pin i.
- R9: The pull bit is active-low: pad_pull_en[i] is 1 when the pull bit is 0.
- R10: Pins at or above NUM_PINS read as 0 in every register, ignore writes, and drive 0 on every pad output.
- R11: Writes to any offset other than a set or clear alias of groups 1 to 7 change no state. This includes base offsets, 0x00 and groups 8 to 15. Reads from any offset whose low nibble is not 0x0, or from groups 8 to 15, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | WIDTH | Write data, one bit per pin |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pad_in | input | WIDTH | Raw pad input levels |
| pad_oe | output | WIDTH | Pad output enable per pin |
| pad_out | output | WIDTH | Pad output value per pin |
| pad_pull_en | output | WIDTH | Pull-up enable per pin |
| pad_role | output | 2*WIDTH | Per-pin role code, two bits per pin |

## Verification
Assertions check a set of rules on every cycle. A set alias leaves the written ones high, and a clear alias leaves them low. Cycles with no alias write, and unmapped writes, leave all state still. Read data never carries bits above NUM_PINS, and no pin drives its output enable while it is in an alternate role. Only the bench's scenarios can show the rest. These are the exact offset map, the two-edge latency of the pin sample, the joint role encoding across function, select and trigger, and the active-low pull sense. The bench shows them with directed sequences and with random traffic compared against a behavioural model on every clock, using a 31-pin instance.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // address bits [3:0] within a register group
  localparam logic [3:0] SUB_BASE = 4'h0;
  localparam logic [3:0] SUB_SET  = 4'h4;
  localparam logic [3:0] SUB_CLR  = 4'h8;

  // address bits [7:4]: group 0 is the pin sample, 1..7 the state registers
  localparam logic [3:0] GRP_PINS = 4'd0;
  localparam logic [3:0] GRP_DATA = 4'd1;
  localparam logic [3:0] GRP_MASK = 4'd2;
  localparam logic [3:0] GRP_PULL = 4'd3;
  localparam logic [3:0] GRP_FUNC = 4'd4;
  localparam logic [3:0] GRP_SEL  = 4'd5;
  localparam logic [3:0] GRP_DIR  = 4'd6;
  localparam logic [3:0] GRP_TRIG = 4'd7;

  localparam int NUM_STATE = 7;

  typedef enum logic [1:0] {
    ROLE_GPIO = 2'd0,
    ROLE_ALT1 = 2'd1,
    ROLE_ALT2 = 2'd2,
    ROLE_ALT3 = 2'd3
  } pin_role_e;

endpackage

// File: rtl/gpio_state_reg.sv
module gpio_state_reg #(
  parameter int WIDTH    = 32,
  parameter int NUM_PINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_bits,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = q;
    q_next = q_next | set_bits;
    q_next = q_next & ~clr_bits;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < NUM_PINS) begin : g_impl
      logic upd;
      assign upd = set_bits[i] | clr_bits[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q[i] <= 1'b0;
        end else if (upd) begin
          q[i] <= q_next[i];
        end
      end
    end else begin : g_none
      assign q[i] = 1'b0;
    end
  end

  // R1: ones written to the set alias are high afterwards
  a_r1_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((q & $past(set_bits)) == $past(set_bits)));

  // R2: ones written to the clear alias are low afterwards
  a_r2_clr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0) |=> ((q & $past(clr_bits)) == '0));

  // R1/R2: with no alias write the register holds
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == '0 && clr_bits == '0) |=> $stable(q));

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH    = 32,
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] level
);

  localparam logic [WIDTH-1:0] IMPL_MASK = {WIDTH{1'b1}} >> (WIDTH - NUM_PINS);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pad_in & IMPL_MASK;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign level = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int NUM_PINS = 32
) (
  input  logic [WIDTH-1:0]   data_q,
  input  logic [WIDTH-1:0]   pull_q,
  input  logic [WIDTH-1:0]   func_q,
  input  logic [WIDTH-1:0]   sel_q,
  input  logic [WIDTH-1:0]   dir_q,
  input  logic [WIDTH-1:0]   trig_q,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_pull_en,
  output logic [2*WIDTH-1:0] pad_role
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_impl
      pin_role_e role;
      always_comb begin
        if (!func_q[i])      role = ROLE_GPIO;
        else if (!sel_q[i])  role = ROLE_ALT1;
        else if (!trig_q[i]) role = ROLE_ALT2;
        else                 role = ROLE_ALT3;
      end
      assign pad_role[2*i +: 2] = role;
      assign pad_oe[i]          = (role == ROLE_GPIO) && dir_q[i];
      assign pad_out[i]         = data_q[i];
      assign pad_pull_en[i]     = ~pull_q[i];
    end else begin : g_none
      assign pad_role[2*i +: 2] = ROLE_GPIO;
      assign pad_oe[i]          = 1'b0;
      assign pad_out[i]         = 1'b0;
      assign pad_pull_en[i]     = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pad_in,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_pull_en,
  output logic [2*WIDTH-1:0] pad_role
);

  localparam logic [WIDTH-1:0] IMPL_MASK = {WIDTH{1'b1}} >> (WIDTH - NUM_PINS);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_ni <= rst_m;
    end
  end

  // address split
  logic [3:0] grp, sub;
  logic       in_bank;
  assign grp     = bus_addr[7:4];
  assign sub     = bus_addr[3:0];
  assign in_bank = ((bus_addr >> 8) == '0);

  logic [NUM_STATE-1:0][WIDTH-1:0] state_q;
  logic [NUM_STATE-1:0][WIDTH-1:0] set_v, clr_v;

  for (genvar g = 0; g < NUM_STATE; g++) begin : g_state
    logic hit;
    assign hit      = bus_we && in_bank && (grp == 4'(g + 1));
    assign set_v[g] = (hit && sub == SUB_SET) ? (bus_wdata & IMPL_MASK) : '0;
    assign clr_v[g] = (hit && sub == SUB_CLR) ? (bus_wdata & IMPL_MASK) : '0;

    gpio_state_reg #(.WIDTH(WIDTH), .NUM_PINS(NUM_PINS)) u_reg (
      .clk      (clk),
      .rst_n    (rst_ni),
      .set_bits (set_v[g]),
      .clr_bits (clr_v[g]),
      .q        (state_q[g])
    );
  end

  logic [WIDTH-1:0] pin_level;
  gpio_pin_sync #(.WIDTH(WIDTH), .NUM_PINS(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .pad_in (pad_in),
    .level  (pin_level)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_bank && sub == SUB_BASE) begin
      if (grp == GRP_PINS) begin
        bus_rdata = pin_level;
      end
      for (int g = 0; g < NUM_STATE; g++) begin
        if (grp == 4'(g + 1)) bus_rdata = state_q[g];
      end
    end
  end

  gpio_pad_map #(.WIDTH(WIDTH), .NUM_PINS(NUM_PINS)) u_map (
    .data_q      (state_q[GRP_DATA - 1]),
    .pull_q      (state_q[GRP_PULL - 1]),
    .func_q      (state_q[GRP_FUNC - 1]),
    .sel_q       (state_q[GRP_SEL  - 1]),
    .dir_q       (state_q[GRP_DIR  - 1]),
    .trig_q      (state_q[GRP_TRIG - 1]),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_role    (pad_role)
  );

  // R10: no read data above the implemented pins
  a_r10_rdata_impl: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bus_rdata & ~IMPL_MASK) == '0));

  // R7: a pin in an alternate role never has its output enabled
  a_r7_alt_no_oe: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pad_oe & state_q[GRP_FUNC - 1]) == '0));

  // R11: writes outside the set/clear aliases leave all state unchanged
  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && !(in_bank && grp >= GRP_DATA && grp <= GRP_TRIG &&
                 (sub == SUB_SET || sub == SUB_CLR))) |=> $stable(state_q));

  // R4: the pin sample offset is read-only
  a_r4_pins_readonly: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && in_bank && grp == GRP_PINS) |=> $stable(state_q));

endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;

  localparam int W  = 32;
  localparam int NP = 31;
  localparam logic [W-1:0] IMPL = {W{1'b1}} >> (W - NP);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     bus_addr;
  logic           bus_we;
  logic [W-1:0]   bus_wdata;
  logic [W-1:0]   bus_rdata;
  logic [W-1:0]   pad_in;
  logic [W-1:0]   pad_oe, pad_out, pad_pull_en;
  logic [2*W-1:0] pad_role;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.WIDTH(W), .NUM_PINS(NP), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_role(pad_role)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit compare_on = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model: index 1..7 = state groups
  logic [W-1:0] m_reg [8];
  logic [W-1:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_reg[k] = '0;
      m_s1 = '0;
      m_s2 = '0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in & IMPL;
      if (bus_we && bus_addr[7:4] >= 1 && bus_addr[7:4] <= 7) begin
        if (bus_addr[3:0] == 4'h4) m_reg[bus_addr[7:4]] = m_reg[bus_addr[7:4]] | (bus_wdata & IMPL);
        if (bus_addr[3:0] == 4'h8) m_reg[bus_addr[7:4]] = m_reg[bus_addr[7:4]] & ~bus_wdata;
      end
    end
  end

  function automatic logic [W-1:0] exp_rd(input logic [7:0] a);
    if (a[3:0] != 4'h0) return '0;
    if (a[7:4] == 0) return m_s2;
    if (a[7:4] <= 7) return m_reg[a[7:4]];
    return '0;
  endfunction

  function automatic logic [2*W-1:0] exp_role();
    logic [2*W-1:0] r = '0;
    for (int i = 0; i < NP; i++) begin
      if (!m_reg[4][i])      r[2*i +: 2] = 2'd0;
      else if (!m_reg[5][i]) r[2*i +: 2] = 2'd1;
      else if (!m_reg[7][i]) r[2*i +: 2] = 2'd2;
      else                   r[2*i +: 2] = 2'd3;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] r = '0;
    for (int i = 0; i < NP; i++) r[i] = m_reg[6][i] && !m_reg[4][i];
    return r;
  endfunction

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (compare_on) begin
      check("R3 rdata vs model", 64'(bus_rdata), 64'(exp_rd(bus_addr)));
      check("R8 pad_out vs model", 64'(pad_out), 64'(m_reg[1]));
      check("R7 pad_oe vs model", 64'(pad_oe), 64'(exp_oe()));
      check("R9 pad_pull_en vs model", 64'(pad_pull_en), 64'(~m_reg[3] & IMPL));
      check("R6 pad_role vs model", pad_role, exp_role());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] v);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    #(20000 * 8);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 compare_on = 1;

    // R5: reset state
    for (int g = 1; g <= 7; g++) begin
      rd(8'(g << 4), v);
      check("R5 register zero after reset", 64'(v), 64'h0);
    end
    @(negedge clk);
    check("R5 pull-up enabled on implemented pins", 64'(pad_pull_en), 64'h7FFF_FFFF);
    check("R5 no output enable", 64'(pad_oe), 64'h0);
    check("R5 all pins GPIO role", pad_role, 64'h0);

    // R1 / R2 / R8
    wr(8'h14, 32'h0000_00F0);
    wr(8'h14, 32'h0000_0003);
    rd(8'h10, v);
    check("R1 set alias ORs bits", 64'(v), 64'h0000_00F3);
    check("R8 pad_out follows data", 64'(pad_out), 64'h0000_00F3);
    wr(8'h18, 32'h0000_0030);
    rd(8'h10, v);
    check("R2 clear alias clears only ones", 64'(v), 64'h0000_00C3);

    // R11: writes to base offset and unmapped offsets are ignored
    wr(8'h10, 32'h0000_FFFF);
    rd(8'h10, v);
    check("R11 write to base offset ignored", 64'(v), 64'h0000_00C3);
    rd(8'h14, v);
    check("R11 read of set alias returns 0", 64'(v), 64'h0);
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h90, v);
    check("R11 group 9 reads 0", 64'(v), 64'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, v);
    check("R11 write to pin offset leaves data", 64'(v), 64'h0000_00C3);

    // R3: mask group round trip
    wr(8'h24, 32'h0000_00AA);
    rd(8'h20, v);
    check("R3 mask group at 0x20", 64'(v), 64'h0000_00AA);

    // R6 / R7: role encoding and output enable
    wr(8'h64, 32'h0000_000F);
    @(negedge clk);
    check("R7 oe follows direction in GPIO role", 64'(pad_oe), 64'h0000_000F);
    wr(8'h44, 32'h0000_0003);
    @(negedge clk);
    check("R6 func=1 sel=0 gives alt 1", 64'(pad_role[3:0]), 64'h5);
    check("R7 alternate pins lose oe", 64'(pad_oe), 64'h0000_000C);
    wr(8'h54, 32'h0000_0003);
    @(negedge clk);
    check("R6 sel=1 trig=0 gives alt 2", 64'(pad_role[3:0]), 64'hA);
    wr(8'h74, 32'h0000_0001);
    @(negedge clk);
    check("R6 sel=1 trig=1 gives alt 3", 64'(pad_role[3:0]), 64'hB);
    wr(8'h48, 32'h0000_0001);
    @(negedge clk);
    check("R6 func cleared returns pin to GPIO", 64'(pad_role[1:0]), 64'h0);
    check("R7 oe back for GPIO output", 64'(pad_oe), 64'h0000_000D);

    // R9: active-low pull
    wr(8'h34, 32'h0000_0005);
    @(negedge clk);
    check("R9 set pull bit disables pull-up", 64'(pad_pull_en), 64'h7FFF_FFFA);
    rd(8'h30, v);
    check("R3 pull group at 0x30", 64'(v), 64'h0000_0005);

    // R4: two-edge pin sample, R10 bit 31 absent
    @(posedge clk); #2;
    bus_addr = 8'h00; pad_in = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check("R4 pin sample not yet after one edge", 64'(bus_rdata), 64'h0);
    @(negedge clk);
    check("R4 pin sample after two edges", 64'(bus_rdata), 64'h7FFF_FFFF);

    // R10: unimplemented pin ignores writes
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, v);
    check("R10 bit 31 not stored", 64'(v), 64'h7FFF_FFFF);
    check("R10 pad_out bit 31 low", 64'(pad_out[31]), 64'h0);

    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #2;
      bus_addr  = {4'($urandom % 10), 4'(($urandom % 4) * 4)};
      bus_we    = 1'($urandom);
      bus_wdata = $urandom;
      pad_in    = $urandom;
    end
    @(posedge clk); #2;
    bus_we = 1'b0;
    @(negedge clk);
    compare_on = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule